// File: doc/BRIEF.md
# Pin Output Register Bank with Atomic Bit Aliases

This block holds the output-value and output-enable registers for a group of pins, together with a read-only register that samples the pin levels. Each register can be reached through four address windows. The two bits above the register offset choose what a write does to the register:

- plain overwrite
- toggle the masked bits
- set the masked bits
- clear the masked bits

Software can therefore flip, raise or drop single pins with one bus write and no read-modify-write. That matters when several agents share one group of pins.

The register bus is a single-cycle port with a write strobe, an address, write data and read data. Read data is registered. It reflects the register selected by the address in the previous cycle and does not depend on the window used. Pin `i` sits at bit `i` of every register. The incoming pin levels pass through a short synchronizer before they reach the sample register.

Top module: `gpio_alias_bank`

## Requirements
- R1: After reset, the output-value and output-enable registers are zero. Every pin is then an input, its output value is low, and read data is zero.
- R2: A write with address bits [13:12]=0 replaces the addressed register with the low NPINS bits of the write data. Offset 0x00 is the output-value register and offset 0x04 is the output-enable register. Write-data bits at or above NPINS are dropped and read back as zero.
- R3: A write with address bits [13:12]=1 (window 0x1000) inverts exactly the register bits that are 1 in the write data. It leaves the other bits unchanged.
- R4: A write with address bits [13:12]=2 (window 0x2000) ORs the write data into the register.
- R5: A write with address bits [13:12]=3 (window 0x3000) ANDs the register with the inverse of the write data.
- R6: The sample register at offset 0x08 is read-only. A write to it through any window leaves it, both writable registers and the pins unchanged.
- R7: A read through any of the four windows returns the plain register contents.
- R8: pad_oe[i] is bit i of the output-enable register, so pin i drives only while that bit is 1. pad_out[i] is bit i of the output-value register. Both change on the clock edge that takes the write.
- R9: A level on pad_in reaches the sample register after SYNC_STAGES clock edges. A read in the same cycle as the pin change still returns the older level.
- R10: Read data is registered. It appears after the edge that samples the address. A read in the same cycle as a write to that register returns the contents from before the write.
- R11: Offsets other than 0x00, 0x04 and 0x08 decode to nothing. Writes there change no register, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address: the top two bits select the alias operation, the rest select the register |
| bus_wdata | input | DATA_W | Write data, used as the value or mask |
| bus_rdata | output | DATA_W | Registered read data |
| pad_out | output | NPINS | Output value for each pin |
| pad_oe | output | NPINS | Drive enable for each pin |
| pad_in | input | NPINS | Raw pin levels |

## Verification
A write lands on the edge that samples it, so the bench reads pad_out and pad_oe at the falling edge that follows that edge.

Read data comes one edge after the address is presented. Every read task therefore drives the address at a falling edge and samples at the next falling edge. A read issued together with a write is expected to return the older contents.

A pin change needs SYNC_STAGES edges before a read's sampling edge can see it. The bench checks both sides of that boundary: an immediate read must return the old level, and a read after the full delay must return the new one.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;

  // Operation chosen by the two address bits above the register offset
  typedef enum logic [1:0] {
    OP_PLAIN  = 2'd0,
    OP_TOGGLE = 2'd1,
    OP_SET    = 2'd2,
    OP_CLEAR  = 2'd3
  } alias_op_e;

  // Register addressed inside one window
  typedef enum logic [1:0] {
    REG_NONE   = 2'd0,
    REG_DOUT   = 2'd1,
    REG_DIR    = 2'd2,
    REG_SAMPLE = 2'd3
  } reg_sel_e;

  localparam int unsigned OFS_DOUT   = 32'h00;
  localparam int unsigned OFS_DIR    = 32'h04;
  localparam int unsigned OFS_SAMPLE = 32'h08;

endpackage

// File: rtl/gpio_alias_decode.sv
module gpio_alias_decode
  import gpio_alias_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr,
  output alias_op_e         op,
  output reg_sel_e          sel
);
  localparam int WIN_LSB = ADDR_W - 2;

  logic [WIN_LSB-1:0] ofs;
  assign ofs = addr[WIN_LSB-1:0];
  assign op  = alias_op_e'(addr[ADDR_W-1:WIN_LSB]);

  always_comb begin
    sel = REG_NONE;
    if (ofs == WIN_LSB'(OFS_DOUT))        sel = REG_DOUT;
    else if (ofs == WIN_LSB'(OFS_DIR))    sel = REG_DIR;
    else if (ofs == WIN_LSB'(OFS_SAMPLE)) sel = REG_SAMPLE;
  end
endmodule

// File: rtl/gpio_alias_update.sv
module gpio_alias_update
  import gpio_alias_pkg::*;
#(
  parameter int W = 28
) (
  input  logic      en,
  input  alias_op_e op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] mask,
  output logic [W-1:0] nxt
);
  always_comb begin
    nxt = cur;
    if (en) begin
      case (op)
        OP_PLAIN:  nxt = mask;
        OP_TOGGLE: nxt = cur ^ mask;
        OP_SET:    nxt = cur | mask;
        OP_CLEAR:  nxt = cur & ~mask;
        default:   nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_sampler.sv
module gpio_pin_sampler #(
  parameter int W      = 28,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  output logic [W-1:0] sampled
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= pins;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign sampled = st[STAGES-1];

  // R9: the first stage takes the pin levels on every edge out of reset
  p_first_stage_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> st[0] == $past(pins));
endmodule

// File: rtl/gpio_alias_bank.sv
module gpio_alias_bank
  import gpio_alias_pkg::*;
#(
  parameter int NPINS       = 28,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  input  logic [NPINS-1:0]  pad_in
);
  alias_op_e op;
  reg_sel_e  sel;
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] dout_q, dir_q, dout_d, dir_d, sample_q;
  logic [DATA_W-1:0] rd_d;

  gpio_alias_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .op(op), .sel(sel)
  );

  assign mask = bus_wdata[NPINS-1:0];

  generate
    if (NPINS < DATA_W) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NPINS];
    end
  endgenerate

  gpio_alias_update #(.W(NPINS)) u_upd_dout (
    .en(bus_we && sel == REG_DOUT), .op(op), .cur(dout_q), .mask(mask), .nxt(dout_d)
  );

  gpio_alias_update #(.W(NPINS)) u_upd_dir (
    .en(bus_we && sel == REG_DIR), .op(op), .cur(dir_q), .mask(mask), .nxt(dir_d)
  );

  gpio_pin_sampler #(.W(NPINS), .STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst(rst), .pins(pad_in), .sampled(sample_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
    end
  end

  // Read path ignores the window bits: every alias returns plain contents
  always_comb begin
    case (sel)
      REG_DOUT:   rd_d = DATA_W'(dout_q);
      REG_DIR:    rd_d = DATA_W'(dir_q);
      REG_SAMPLE: rd_d = DATA_W'(sample_q);
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;

  // R2: plain write to the enable register replaces it with the mask
  p_plain_dir_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && sel == REG_DIR && op == OP_PLAIN) |=> dir_q == $past(mask));

  // R3: toggle write flips exactly the masked bits
  p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && sel == REG_DOUT && op == OP_TOGGLE) |=> (dout_q ^ $past(dout_q)) == $past(mask));

  // R4: set write leaves all masked bits at one
  p_set_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && sel == REG_DOUT && op == OP_SET) |=> (dout_q & $past(mask)) == $past(mask));

  // R5: clear write leaves all masked bits at zero
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && sel == REG_DOUT && op == OP_CLEAR) |=> (dout_q & $past(mask)) == '0);

  // R6: writes to the sample register touch no writable register
  p_sample_ro_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_we && sel == REG_SAMPLE) |=> ($stable(dout_q) && $stable(dir_q)));

  // R7 / R10: read data is the pre-edge contents whatever the window
  p_read_dout_r7: assert property (@(posedge clk) disable iff (rst)
    (sel == REG_DOUT) |=> bus_rdata == DATA_W'($past(dout_q)));

  // R11: undecoded offsets leave both registers and read as zero
  p_undecoded_r11: assert property (@(posedge clk) disable iff (rst)
    (sel == REG_NONE) |=> ($stable(dout_q) && $stable(dir_q) && bus_rdata == '0));
endmodule

// File: tb/gpio_alias_bank_tb.sv
module gpio_alias_bank_tb;
  localparam int NPINS = 28;
  localparam int DW = 32;
  localparam int AW = 14;
  localparam int SYNC = 2;
  localparam logic [NPINS-1:0] PMASK = '1;

  localparam logic [AW-1:0] A_DOUT = 14'h0000;
  localparam logic [AW-1:0] A_DIR  = 14'h0004;
  localparam logic [AW-1:0] A_IN   = 14'h0008;
  localparam logic [AW-1:0] W_XOR  = 14'h1000;
  localparam logic [AW-1:0] W_SET  = 14'h2000;
  localparam logic [AW-1:0] W_CLR  = 14'h3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NPINS-1:0] pad_out, pad_oe;
  logic [NPINS-1:0] pad_in = '0;

  int total = 0;
  int bad = 0;
  logic [NPINS-1:0] exp_out = '0;
  logic [NPINS-1:0] exp_oe = '0;

  always #10 clk = ~clk;

  gpio_alias_bank #(.NPINS(NPINS), .DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic check_regs(input string req);
    logic [DW-1:0] v;
    bus_read(A_DOUT, v); check(req, v, DW'(exp_out));
    bus_read(A_DIR, v);  check(req, v, DW'(exp_oe));
    check(req, DW'(pad_out), DW'(exp_out));
    check(req, DW'(pad_oe), DW'(exp_oe));
  endtask

  task automatic t_reset;
    check("R1", DW'(pad_oe), '0);
    check("R1", DW'(pad_out), '0);
    check("R1", bus_rdata, '0);
    check_regs("R1");
  endtask

  task automatic t_plain;
    bus_write(A_DOUT, 32'hFFFF_FFFF); exp_out = PMASK;
    check_regs("R2");
    bus_write(A_DOUT, 32'h1234_5678); exp_out = 28'h234_5678;
    bus_write(A_DIR, 32'hF0A5_5A5A);  exp_oe = 28'h0A5_5A5A;
    check_regs("R2");
  endtask

  task automatic t_toggle;
    bus_write(W_XOR | A_DOUT, 32'h0000_F00F); exp_out = exp_out ^ 28'h000_F00F;
    check_regs("R3");
    bus_write(W_XOR | A_DIR, 32'h0FFF_FFFF); exp_oe = ~exp_oe;
    check_regs("R3");
    bus_write(W_XOR | A_DIR, 32'h0FFF_FFFF); exp_oe = ~exp_oe;
    check_regs("R3");
  endtask

  task automatic t_set;
    bus_write(A_DOUT, 32'h0000_0011); exp_out = 28'h000_0011;
    bus_write(W_SET | A_DOUT, 32'h0800_0101); exp_out = 28'h800_0111;
    check_regs("R4");
  endtask

  task automatic t_clear;
    bus_write(W_CLR | A_DOUT, 32'h0800_0010); exp_out = 28'h000_0101;
    bus_write(W_CLR | A_DIR, 32'h0000_00FF); exp_oe = exp_oe & ~28'h000_00FF;
    check_regs("R5");
  endtask

  task automatic t_input_ro;
    logic [DW-1:0] v;
    pad_in = 28'hA5C_3F01;
    repeat (SYNC + 1) @(negedge clk);
    bus_write(A_IN, 32'h0000_0000);
    bus_write(W_XOR | A_IN, 32'hFFFF_FFFF);
    bus_write(W_SET | A_IN, 32'hFFFF_FFFF);
    bus_write(W_CLR | A_IN, 32'hFFFF_FFFF);
    bus_read(A_IN, v); check("R6", v, DW'(28'hA5C_3F01));
    check_regs("R6");
  endtask

  task automatic t_alias_read;
    logic [DW-1:0] v;
    bus_read(W_XOR | A_DOUT, v); check("R7", v, DW'(exp_out));
    bus_read(W_SET | A_DIR, v);  check("R7", v, DW'(exp_oe));
    bus_read(W_CLR | A_IN, v);   check("R7", v, DW'(28'hA5C_3F01));
  endtask

  task automatic t_drive;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = A_DIR; bus_wdata = 32'h0000_0003;
    @(negedge clk);
    bus_we = 1'b0;
    exp_oe = 28'h000_0003;
    check("R8", DW'(pad_oe), DW'(exp_oe));
    bus_write(W_SET | A_DOUT, 32'h0000_0002); exp_out = exp_out | 28'h2;
    check("R8", DW'(pad_out), DW'(exp_out));
  endtask

  task automatic t_sample;
    logic [DW-1:0] v;
    @(negedge clk);
    pad_in = 28'h0F0_0F0F; bus_addr = A_IN;
    @(negedge clk);
    check("R9", bus_rdata, DW'(28'hA5C_3F01));
    repeat (SYNC) @(negedge clk);
    bus_read(A_IN, v); check("R9", v, DW'(28'h0F0_0F0F));
  endtask

  task automatic t_rdw;
    logic [DW-1:0] v;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = A_DOUT; bus_wdata = 32'h0BAD_CAFE;
    @(negedge clk);
    bus_we = 1'b0;
    check("R10", bus_rdata, DW'(exp_out));
    exp_out = 28'hBAD_CAFE;
    bus_read(A_DOUT, v); check("R10", v, DW'(exp_out));
  endtask

  task automatic t_undecoded;
    logic [DW-1:0] v;
    bus_write(14'h000C, 32'hFFFF_FFFF);
    bus_write(W_SET | 14'h0010, 32'hFFFF_FFFF);
    bus_write(W_CLR | 14'h0001, 32'hFFFF_FFFF);
    bus_read(14'h000C, v); check("R11", v, '0);
    check_regs("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain();
    t_toggle();
    t_set();
    t_clear();
    t_input_ro();
    t_alias_read();
    t_drive();
    t_sample();
    t_rdw();
    t_undecoded();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule